// File: doc/BRIEF.md
# Shift and Sign-Extend Unit

This block is the shift datapath of a 32-bit integer pipeline. It takes one operand, a shift amount drawn either from a register value or from an immediate field, a three-bit operation code and the current carry flag. It returns a result word, a new carry value and a strobe that says whether the carry flag is to be written.

Three kinds of work share the unit:
- **Barrel shifts** move the operand by 0 to 31 places: logical right, arithmetic right or left.
- **Single-bit right shifts** move the operand by one place and hand bit 0 to the carry flag. In the arithmetic variant the vacated top bit keeps the sign. In the logical variant it takes zero. In the rotate variant it takes the old carry.
- **Sign extension** widens a signed byte or a signed halfword to a full word.

Instruction decode and operand muxing sit upstream. The caller owns the carry flag and updates it from the unit's outputs.

Top module: `shx_unit`

## Requirements
- R1: While `rst_n` is low, `res`, `carry_out`, `carry_we` and `res_valid` are all 0.
- R2: Results are registered. `res_valid` is `op_valid` delayed by one clock. When `op_valid` is 0, the next cycle shows `res_valid`=0 and `carry_we`=0, and `res` keeps its previous value.
- R3: Op codes 0, 1 and 2 shift by the low 5 bits of the selected amount (`shamt_imm` when `use_imm`=1, else `shamt_reg`). Code 0 is a logical right shift, code 1 an arithmetic right shift and code 2 a left shift. The upper amount bits are ignored.
- R4: A barrel shift with amount 0 returns the operand unchanged, for all three barrel codes.
- R5: Op code 3 (single arithmetic right) returns the operand shifted right by one, with bit 31 kept.
- R6: Op code 4 (single rotate through carry) returns the operand shifted right by one, with `carry_in` placed in bit 31.
- R7: Op code 5 (single logical right) returns the operand shifted right by one, with 0 in bit 31.
- R8: For op codes 3, 4 and 5, `carry_we`=1 and `carry_out` equals bit 0 of the operand. Chained single-bit shifts that feed `carry_out` back as `carry_in` therefore move the carry through the word.
- R9: Op code 6 copies operand bit 7 into bits 31..8. Op code 7 copies operand bit 15 into bits 31..16. The low bits pass through unchanged.
- R10: For op codes 0, 1, 2, 6 and 7, `carry_we`=0 and `carry_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code (0..7, see R3..R9) |
| operand_a | input | 32 | Value to shift or extend |
| shamt_reg | input | 32 | Register shift amount (low 5 bits used) |
| shamt_imm | input | 16 | Immediate shift amount (low 5 bits used) |
| use_imm | input | 1 | 1 selects `shamt_imm`, 0 selects `shamt_reg` |
| carry_in | input | 1 | Current carry flag |
| res | output | 32 | Result word |
| carry_out | output | 1 | New carry value |
| carry_we | output | 1 | Carry flag write strobe |
| res_valid | output | 1 | Result valid |

## Verification
Every result, the carry value and the carry strobe become visible one clock after the edge that captures the operation. The bench therefore drives inputs on the falling edge and reads the outputs a quarter period after the next rising edge, before anything else changes.

Idle cycles are read at the same point. This shows that `res` held its value and that no carry write appeared.

Carry chaining is checked by feeding each single-bit result's `carry_out` back as the next `carry_in`. The bench compares each step against its own running model of the flag.

// File: rtl/shx_pkg.sv
package shx_pkg;

   typedef enum logic [2:0] {
      OP_BSRL  = 3'd0,
      OP_BSRA  = 3'd1,
      OP_BSLL  = 3'd2,
      OP_SRA1  = 3'd3,
      OP_SRC1  = 3'd4,
      OP_SRL1  = 3'd5,
      OP_SEXTB = 3'd6,
      OP_SEXTH = 3'd7
   } shx_op_e;

   function automatic logic is_single(input shx_op_e op);
      return (op == OP_SRA1) || (op == OP_SRC1) || (op == OP_SRL1);
   endfunction

   function automatic logic is_barrel(input shx_op_e op);
      return (op == OP_BSRL) || (op == OP_BSRA) || (op == OP_BSLL);
   endfunction

endpackage

// File: rtl/shx_barrel.sv
module shx_barrel #(
   parameter int DATA_W = 32,
   parameter bit LOG_STAGES = 1'b1,
   localparam int SH_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   input  logic              go_left,
   input  logic              arith,
   output logic [DATA_W-1:0] dout
);

   initial begin
      if ((1 << SH_W) != DATA_W) $error("shx_barrel: DATA_W must be a power of two");
   end

   generate
      if (LOG_STAGES) begin : g_log
         logic [DATA_W-1:0] rev_in;
         logic [DATA_W-1:0] rev_out;
         logic [DATA_W-1:0] stg [0:SH_W];
         logic              fill;

         for (genvar i = 0; i < DATA_W; i++) begin : g_rev
            assign rev_in[i]  = din[DATA_W-1-i];
            assign rev_out[i] = stg[SH_W][DATA_W-1-i];
         end

         assign fill   = arith & ~go_left & din[DATA_W-1];
         assign stg[0] = go_left ? rev_in : din;

         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int D = 1 << k;
            assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][DATA_W-1:D]} : stg[k];
         end

         assign dout = go_left ? rev_out : stg[SH_W];
      end else begin : g_ops
         always_comb begin
            if (go_left)
               dout = din << amt;
            else if (arith)
               dout = DATA_W'($signed(din) >>> amt);
            else
               dout = din >> amt;
         end
      end
   endgenerate

endmodule

// File: rtl/shx_single.sv
module shx_single #(
   parameter int DATA_W = 32
) (
   input  shx_pkg::shx_op_e  op,
   input  logic [DATA_W-1:0] din,
   input  logic              cin,
   output logic [DATA_W-1:0] dout,
   output logic              cout
);
   import shx_pkg::*;

   logic top_bit;

   always_comb begin
      unique case (op)
         OP_SRA1: top_bit = din[DATA_W-1];
         OP_SRC1: top_bit = cin;
         default: top_bit = 1'b0;
      endcase
   end

   assign dout = {top_bit, din[DATA_W-1:1]};
   assign cout = din[0];

endmodule

// File: rtl/shx_sext.sv
module shx_sext #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16
) (
   input  logic              half,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   initial begin
      if (BYTE_W < 1 || BYTE_W >= HALF_W || HALF_W >= DATA_W)
         $error("shx_sext: need 0 < BYTE_W < HALF_W < DATA_W");
   end

   logic [DATA_W-1:0] ext_b;
   logic [DATA_W-1:0] ext_h;

   assign ext_b = {{(DATA_W-BYTE_W){din[BYTE_W-1]}}, din[BYTE_W-1:0]};
   assign ext_h = {{(DATA_W-HALF_W){din[HALF_W-1]}}, din[HALF_W-1:0]};
   assign dout  = half ? ext_h : ext_b;

endmodule

// File: rtl/shx_unit.sv
module shx_unit #(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 16,
   parameter int BYTE_W     = 8,
   parameter int HALF_W     = 16,
   parameter bit LOG_STAGES = 1'b1,
   parameter bit OUT_REG    = 1'b1,
   localparam int SH_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] operand_a,
   input  logic [DATA_W-1:0] shamt_reg,
   input  logic [IMM_W-1:0]  shamt_imm,
   input  logic              use_imm,
   input  logic              carry_in,
   output logic [DATA_W-1:0] res,
   output logic              carry_out,
   output logic              carry_we,
   output logic              res_valid
);
   import shx_pkg::*;

   initial begin
      if (IMM_W < SH_W) $error("shx_unit: IMM_W must hold a full shift amount");
   end

   shx_op_e           op;
   logic [SH_W-1:0]   amt;
   logic [DATA_W-1:0] bar_res, one_res, ext_res;
   logic              one_cy;
   logic [DATA_W-1:0] nxt_res;
   logic              nxt_cy, nxt_we;
   logic              unused_hi;

   assign op  = shx_op_e'(op_sel);
   assign amt = use_imm ? shamt_imm[SH_W-1:0] : shamt_reg[SH_W-1:0];
   assign unused_hi = ^{shamt_reg[DATA_W-1:SH_W], shamt_imm[IMM_W-1:SH_W]};

   shx_barrel #(.DATA_W(DATA_W), .LOG_STAGES(LOG_STAGES)) u_barrel (
      .din     (operand_a),
      .amt     (amt),
      .go_left (op == OP_BSLL),
      .arith   (op == OP_BSRA),
      .dout    (bar_res)
   );

   shx_single #(.DATA_W(DATA_W)) u_single (
      .op   (op),
      .din  (operand_a),
      .cin  (carry_in),
      .dout (one_res),
      .cout (one_cy)
   );

   shx_sext #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_sext (
      .half (op == OP_SEXTH),
      .din  (operand_a),
      .dout (ext_res)
   );

   always_comb begin
      nxt_we = op_valid & is_single(op);
      nxt_cy = nxt_we & one_cy;
      if (is_barrel(op))
         nxt_res = bar_res;
      else if (is_single(op))
         nxt_res = one_res;
      else
         nxt_res = ext_res;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               res       <= '0;
               carry_out <= 1'b0;
               carry_we  <= 1'b0;
               res_valid <= 1'b0;
            end else begin
               res_valid <= op_valid;
               carry_we  <= nxt_we;
               carry_out <= nxt_cy;
               if (op_valid) res <= nxt_res;
            end
         end
      end else begin : g_comb
         assign res       = rst_n ? nxt_res : '0;
         assign carry_out = rst_n & nxt_cy;
         assign carry_we  = rst_n & nxt_we;
         assign res_valid = rst_n & op_valid;
      end
   endgenerate

endmodule

// File: rtl/shx_unit_chk.sv
module shx_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int BYTE_W  = 8,
   parameter int HALF_W  = 16,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_sel,
   input logic [DATA_W-1:0] operand_a,
   input logic              carry_in,
   input logic [DATA_W-1:0] res,
   input logic              carry_out,
   input logic              carry_we,
   input logic              res_valid
);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   generate
      if (OUT_REG) begin : g_chk
         // R2
         valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> (res_valid == $past(op_valid)));

         // R2
         idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !res_valid) |-> ($stable(res) && !carry_we));

         // R8
         carry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && carry_we) |-> (carry_out == $past(operand_a[0])
                                       && $past(op_sel) >= 3'd3 && $past(op_sel) <= 3'd5));

         // R10
         carry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && res_valid && ($past(op_sel) <= 3'd2 || $past(op_sel) >= 3'd6))
               |-> (!carry_we && !carry_out));

         // R6
         rotate_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && res_valid && $past(op_sel) == 3'd4)
               |-> (res[DATA_W-1] == $past(carry_in)));

         // R9
         sext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && res_valid && $past(op_sel) == 3'd6)
               |-> (res[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){res[BYTE_W-1]}}));

         // R9
         sext_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && res_valid && $past(op_sel) == 3'd7)
               |-> (res[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){res[HALF_W-1]}}));
      end
   endgenerate

   // R1
   always @(negedge clk) begin
      if (!rst_n && past_ok == 1'b0 && OUT_REG) begin
         reset_state_chk: assert (res_valid == 1'b0 || $isunknown(res_valid));
      end
   end

endmodule

bind shx_unit shx_unit_chk #(
   .DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
   .operand_a(operand_a), .carry_in(carry_in), .res(res),
   .carry_out(carry_out), .carry_we(carry_we), .res_valid(res_valid)
);

// File: tb/tb_shx_unit.sv
module tb_shx_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [31:0] operand_a = '0;
   logic [31:0] shamt_reg = '0;
   logic [15:0] shamt_imm = '0;
   logic        use_imm = 1'b0;
   logic        carry_in = 1'b0;
   logic [31:0] res;
   logic        carry_out, carry_we, res_valid;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   shx_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .operand_a(operand_a), .shamt_reg(shamt_reg), .shamt_imm(shamt_imm),
      .use_imm(use_imm), .carry_in(carry_in), .res(res),
      .carry_out(carry_out), .carry_we(carry_we), .res_valid(res_valid)
   );

   function automatic logic [31:0] ref_res(input logic [2:0] op, input logic [31:0] a,
                                           input logic [4:0] n, input logic c);
      case (op)
         3'd0: return a >> n;
         3'd1: return 32'($signed(a) >>> n);
         3'd2: return a << n;
         3'd3: return {a[31], a[31:1]};
         3'd4: return {c, a[31:1]};
         3'd5: return {1'b0, a[31:1]};
         3'd6: return {{24{a[7]}}, a[7:0]};
         default: return {{16{a[15]}}, a[15:0]};
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // issue one operation, sample a quarter period after the capturing edge
   task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] sreg, input logic [15:0] simm,
                         input logic ui, input logic c);
      logic [4:0] n;
      logic       single;
      @(negedge clk);
      op_valid = 1'b1; op_sel = op; operand_a = a; shamt_reg = sreg;
      shamt_imm = simm; use_imm = ui; carry_in = c;
      @(posedge clk);
      #(CLK_P/4);
      n = ui ? simm[4:0] : sreg[4:0];
      single = (op >= 3'd3 && op <= 3'd5);
      chk(tag, res, ref_res(op, a, n, c));
      chk({tag, " valid R2"}, 32'(res_valid), 32'd1);
      if (single) begin
         chk({tag, " we R8"}, 32'(carry_we), 32'd1);
         chk({tag, " cy R8"}, 32'(carry_out), 32'(a[0]));
      end else begin
         chk({tag, " we R10"}, 32'(carry_we), 32'd0);
         chk({tag, " cy R10"}, 32'(carry_out), 32'd0);
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: actual=expired expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, prev;
      logic        flag;
      void'($urandom(32'h5EED_0042));

      // R1: reset state
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      chk("R1 res", res, 32'd0);
      chk("R1 we", 32'(carry_we), 32'd0);
      chk("R1 valid", 32'(res_valid), 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R3 R4: every amount, each barrel type, register and immediate forms
      for (int n = 0; n < 32; n++) begin
         for (int op = 0; op < 3; op++) begin
            a = $urandom() | 32'h8000_0001;
            run_op(n == 0 ? "R4 reg" : "R3 reg", 3'(op), a,
                   ($urandom() & 32'hFFFF_FFE0) | 32'(n), 16'($urandom()), 1'b0, 1'($urandom()));
            a = $urandom() & 32'h7FFF_FFFF;
            run_op(n == 0 ? "R4 imm" : "R3 imm", 3'(op), a,
                   $urandom(), (16'($urandom()) & 16'hFFE0) | 16'(n), 1'b1, 1'($urandom()));
         end
      end

      // R5 R6 R7: directed corners
      run_op("R5 neg", 3'd3, 32'h8000_0001, 0, 0, 0, 1'b0);
      run_op("R5 pos", 3'd3, 32'h7FFF_FFFE, 0, 0, 0, 1'b1);
      run_op("R6 c1", 3'd4, 32'h0000_0003, 0, 0, 0, 1'b1);
      run_op("R6 c0", 3'd4, 32'hFFFF_FFFE, 0, 0, 0, 1'b0);
      run_op("R7 ones", 3'd7 - 3'd2, 32'hFFFF_FFFF, 0, 0, 0, 1'b1);

      // R9: sign extension boundaries
      run_op("R9 b neg", 3'd6, 32'h1234_5680, 0, 0, 0, 1'b1);
      run_op("R9 b pos", 3'd6, 32'hFFFF_FF7F, 0, 0, 0, 1'b0);
      run_op("R9 h neg", 3'd7, 32'h0000_8001, 0, 0, 0, 1'b1);
      run_op("R9 h pos", 3'd7, 32'hFFFF_7FFF, 0, 0, 0, 1'b0);

      // R8: carry chaining across successive single-bit shifts
      a = 32'hA5C3_0F71;
      flag = 1'b0;
      for (int i = 0; i < 40; i++) begin
         logic [2:0] op;
         op = 3'd3 + 3'($urandom_range(0, 2));
         run_op("R8 chain", op, a, 0, 0, 0, flag);
         chk("R8 chain flag", 32'(carry_out), 32'(a[0]));
         a = ref_res(op, a, 5'd0, flag);
         flag = carry_out;
      end

      // random mix, all codes
      for (int i = 0; i < 300; i++) begin
         run_op("R3 R9 mix", 3'($urandom()), $urandom(), $urandom(),
                16'($urandom()), 1'($urandom()), 1'($urandom()));
      end

      // R2: idle cycle holds result and writes no carry
      run_op("R2 pre", 3'd5, 32'h0000_0011, 0, 0, 0, 1'b0);
      prev = res;
      @(negedge clk);
      op_valid = 1'b0; op_sel = 3'd2; operand_a = 32'hDEAD_BEEF; shamt_reg = 32'd4;
      @(posedge clk);
      #(CLK_P/4);
      chk("R2 hold", res, prev);
      chk("R2 idle valid", 32'(res_valid), 32'd0);
      chk("R2 idle we", 32'(carry_we), 32'd0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule